// File: doc/BRIEF.md
# Precise exception capture unit

This block sits next to the execute stage of a simple in-order processor and turns per-instruction fault events into a precise trap. Each cycle the datapath presents the address of the instruction being retired, its request to write a destination register, and two event flags: a signed arithmetic overflow and an unrecognised opcode. When either event is raised for a valid instruction, the unit blocks the register write in that same cycle and steers the next fetch to one fixed handler entry point. At the clock edge it also saves the faulting instruction's own address, records why the trap happened in a cause word, and switches the processor to privileged mode.

A single handler serves every trap and reads the cause word to tell the reasons apart. When the handler finishes it raises the return input. The unit then steers the next fetch back to the saved address and drops privileged mode at the following edge. Trap codes, the code field position, the handler address and the event priority are all parameters.

Top module: `trap_capture_unit`

## Requirements
- R1: While reset is asserted and after it is released, the saved address, the cause word and the privileged-mode flag all read zero.
- R2: In any cycle where a valid instruction raises overflow or undefined-opcode, `rd_we_o` is low in that same cycle. In all other cycles `rd_we_o` equals `rd_we_req_i`.
- R3: At the edge that ends an accepted trap cycle, `epc_o` takes the value of `instr_pc_i` from that cycle, which is the address of the faulting instruction and not the one after it.
- R4: An accepted overflow-only trap writes code 12 into cause bits 6:2, so `cause_o` equals 0x30. Every cause bit outside 6:2 reads zero.
- R5: An accepted undefined-opcode trap writes code 10 into cause bits 6:2, so `cause_o` equals 0x28.
- R6: When overflow and undefined-opcode are raised together, the undefined-opcode code (10) is recorded.
- R7: In an accepted trap cycle, `fetch_redir_o` is high and `fetch_target_o` is 0x80000180, whatever the cause.
- R8: After an accepted trap, `kernel_o` reads 1.
- R9: A return request in a cycle without an accepted trap drives `fetch_redir_o` high with `fetch_target_o` equal to the current `epc_o`. At the next edge `kernel_o` clears, and `epc_o` and `cause_o` stay unchanged.
- R10: In cycles with no accepted trap, `epc_o` and `cause_o` hold their values. This includes cycles where event flags are raised while `instr_vld_i` is low. With no return request in such a cycle, `fetch_redir_o` is low.
- R11: A trap and a return request in the same cycle behave as the trap alone: the vector is fetched and `kernel_o` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_vld_i | input | 1 | An instruction is completing this cycle |
| instr_pc_i | input | 32 | Address of the completing instruction |
| rd_we_req_i | input | 1 | Datapath request to write the destination register |
| ovf_evt_i | input | 1 | Signed arithmetic overflow on this instruction |
| undef_evt_i | input | 1 | Opcode not recognised |
| eret_i | input | 1 | Return from handler |
| rd_we_o | output | 1 | Gated destination write enable |
| fetch_redir_o | output | 1 | Override the next fetch address |
| fetch_target_o | output | 32 | Next fetch address when overriding |
| epc_o | output | 32 | Saved faulting instruction address |
| cause_o | output | 32 | Cause word, code in bits 6:2 |
| kernel_o | output | 1 | Privileged-mode flag |

## Verification
The write gate and the fetch override are combinational, so the bench checks them one time unit after it drives the inputs, before the clock edge of that same cycle. The saved address, the cause word and the mode flag each pass through one register, so the bench checks them one time unit after the next rising edge, against a model it updates at that edge. The sweep walks all 32 combinations of the five control inputs, four times over, with different instruction addresses. This covers both event priorities, traps that collide with a return, and ignored events on invalid slots.

// File: rtl/trap_pkg.sv
package trap_pkg;

   // Which trap, if any, is accepted in the current cycle
   typedef enum logic [1:0] {
      TRAP_NONE  = 2'd0,
      TRAP_OVF   = 2'd1,
      TRAP_UNDEF = 2'd2
   } trap_kind_e;

   localparam int unsigned DEF_ADDR_W    = 32;
   localparam int unsigned DEF_CAUSE_W   = 32;
   localparam int unsigned DEF_CODE_LSB  = 2;
   localparam int unsigned DEF_CODE_W    = 5;
   localparam int unsigned DEF_OVF_CODE  = 12;
   localparam int unsigned DEF_UNDEF_CODE = 10;
   localparam logic [31:0] DEF_HANDLER_VEC = 32'h8000_0180;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter bit UNDEF_WINS = 1'b1
) (
   input  logic       vld_i,
   input  logic       ovf_i,
   input  logic       undef_i,
   output trap_kind_e kind_o
);

   logic       any_evt;
   trap_kind_e pick;

   assign any_evt = vld_i & (ovf_i | undef_i);

   generate
      if (UNDEF_WINS) begin : g_undef_first
         always_comb begin
            if (undef_i)    pick = TRAP_UNDEF;
            else if (ovf_i) pick = TRAP_OVF;
            else            pick = TRAP_NONE;
         end
      end else begin : g_ovf_first
         always_comb begin
            if (ovf_i)        pick = TRAP_OVF;
            else if (undef_i) pick = TRAP_UNDEF;
            else              pick = TRAP_NONE;
         end
      end
   endgenerate

   assign kind_o = any_evt ? pick : TRAP_NONE;

endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
   import trap_pkg::*;
#(
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned CAUSE_W    = DEF_CAUSE_W,
   parameter int unsigned CODE_LSB   = DEF_CODE_LSB,
   parameter int unsigned CODE_W     = DEF_CODE_W,
   parameter int unsigned OVF_CODE   = DEF_OVF_CODE,
   parameter int unsigned UNDEF_CODE = DEF_UNDEF_CODE
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  trap_kind_e        kind_i,
   input  logic              eret_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] epc_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic              kernel_o
);

   localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;
   localparam logic [CODE_W-1:0] OVF_C   = CODE_W'(OVF_CODE);
   localparam logic [CODE_W-1:0] UNDEF_C = CODE_W'(UNDEF_CODE);

   logic               take;
   logic [CODE_W-1:0]  code_sel;
   logic [CAUSE_W-1:0] cause_d;
   logic [ADDR_W-1:0]  epc_q;
   logic [CAUSE_W-1:0] cause_q;
   logic               kernel_q;

   assign take = (kind_i != TRAP_NONE);

   always_comb begin
      unique case (kind_i)
         TRAP_UNDEF: code_sel = UNDEF_C;
         TRAP_OVF:   code_sel = OVF_C;
         default:    code_sel = '0;
      endcase
   end

   always_comb begin
      cause_d = '0;
      cause_d[CODE_MSB:CODE_LSB] = code_sel;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         epc_q   <= '0;
         cause_q <= '0;
      end else if (take) begin
         epc_q   <= pc_i;
         cause_q <= cause_d;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     kernel_q <= 1'b0;
      else if (take)   kernel_q <= 1'b1;
      else if (eret_i) kernel_q <= 1'b0;
   end

   assign epc_o    = epc_q;
   assign cause_o  = cause_q;
   assign kernel_o = kernel_q;

endmodule

// File: rtl/trap_fetch_redirect.sv
module trap_fetch_redirect
   import trap_pkg::*;
#(
   parameter int unsigned        ADDR_W      = DEF_ADDR_W,
   parameter logic [ADDR_W-1:0]  HANDLER_VEC = ADDR_W'(DEF_HANDLER_VEC)
) (
   input  trap_kind_e        kind_i,
   input  logic              eret_i,
   input  logic              we_req_i,
   input  logic [ADDR_W-1:0] epc_i,
   output logic              we_o,
   output logic              redir_o,
   output logic [ADDR_W-1:0] target_o
);

   logic take;

   assign take = (kind_i != TRAP_NONE);

   // A faulting instruction never commits its result
   assign we_o = we_req_i & ~take;

   always_comb begin
      redir_o  = 1'b0;
      target_o = '0;
      if (take) begin
         redir_o  = 1'b1;
         target_o = HANDLER_VEC;
      end else if (eret_i) begin
         redir_o  = 1'b1;
         target_o = epc_i;
      end
   end

endmodule

// File: rtl/trap_capture_unit.sv
module trap_capture_unit
   import trap_pkg::*;
#(
   parameter int unsigned       ADDR_W      = DEF_ADDR_W,
   parameter int unsigned       CAUSE_W     = DEF_CAUSE_W,
   parameter int unsigned       CODE_LSB    = DEF_CODE_LSB,
   parameter int unsigned       CODE_W      = DEF_CODE_W,
   parameter int unsigned       OVF_CODE    = DEF_OVF_CODE,
   parameter int unsigned       UNDEF_CODE  = DEF_UNDEF_CODE,
   parameter logic [ADDR_W-1:0] HANDLER_VEC = ADDR_W'(DEF_HANDLER_VEC),
   parameter bit                UNDEF_WINS  = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               instr_vld_i,
   input  logic [ADDR_W-1:0]  instr_pc_i,
   input  logic               rd_we_req_i,
   input  logic               ovf_evt_i,
   input  logic               undef_evt_i,
   input  logic               eret_i,
   output logic               rd_we_o,
   output logic               fetch_redir_o,
   output logic [ADDR_W-1:0]  fetch_target_o,
   output logic [ADDR_W-1:0]  epc_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic               kernel_o
);

   localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;

   // Elaboration-time parameter checks
   generate
      if (CODE_MSB >= CAUSE_W) begin : g_bad_field
         $error("cause code field does not fit in the cause word");
      end
      if (OVF_CODE >= (1 << CODE_W) || UNDEF_CODE >= (1 << CODE_W)) begin : g_bad_code
         $error("trap code exceeds the code field width");
      end
      if (OVF_CODE == UNDEF_CODE) begin : g_same_code
         $error("trap codes must differ");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("address width too small");
      end
   endgenerate

   trap_kind_e        kind;
   logic [ADDR_W-1:0] epc_q;

   trap_arbiter #(
      .UNDEF_WINS (UNDEF_WINS)
   ) arb_i (
      .vld_i   (instr_vld_i),
      .ovf_i   (ovf_evt_i),
      .undef_i (undef_evt_i),
      .kind_o  (kind)
   );

   trap_state_regs #(
      .ADDR_W     (ADDR_W),
      .CAUSE_W    (CAUSE_W),
      .CODE_LSB   (CODE_LSB),
      .CODE_W     (CODE_W),
      .OVF_CODE   (OVF_CODE),
      .UNDEF_CODE (UNDEF_CODE)
   ) regs_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .kind_i   (kind),
      .eret_i   (eret_i),
      .pc_i     (instr_pc_i),
      .epc_o    (epc_q),
      .cause_o  (cause_o),
      .kernel_o (kernel_o)
   );

   trap_fetch_redirect #(
      .ADDR_W      (ADDR_W),
      .HANDLER_VEC (HANDLER_VEC)
   ) redir_i (
      .kind_i   (kind),
      .eret_i   (eret_i),
      .we_req_i (rd_we_req_i),
      .epc_i    (epc_q),
      .we_o     (rd_we_o),
      .redir_o  (fetch_redir_o),
      .target_o (fetch_target_o)
   );

   assign epc_o = epc_q;

endmodule

// File: rtl/trap_capture_chk.sv
module trap_capture_chk #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       CAUSE_W     = 32,
   parameter int unsigned       CODE_LSB    = 2,
   parameter int unsigned       CODE_W      = 5,
   parameter int unsigned       OVF_CODE    = 12,
   parameter int unsigned       UNDEF_CODE  = 10,
   parameter logic [ADDR_W-1:0] HANDLER_VEC = 32'h8000_0180,
   parameter bit                UNDEF_WINS  = 1'b1
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               instr_vld_i,
   input logic [ADDR_W-1:0]  instr_pc_i,
   input logic               rd_we_req_i,
   input logic               ovf_evt_i,
   input logic               undef_evt_i,
   input logic               eret_i,
   input logic               rd_we_o,
   input logic               fetch_redir_o,
   input logic [ADDR_W-1:0]  fetch_target_o,
   input logic [ADDR_W-1:0]  epc_o,
   input logic [CAUSE_W-1:0] cause_o,
   input logic               kernel_o
);

   localparam logic [CAUSE_W-1:0] OVF_WORD   = CAUSE_W'(OVF_CODE) << CODE_LSB;
   localparam logic [CAUSE_W-1:0] UNDEF_WORD = CAUSE_W'(UNDEF_CODE) << CODE_LSB;
   localparam logic [CAUSE_W-1:0] BOTH_WORD  = UNDEF_WINS ? UNDEF_WORD : OVF_WORD;

   logic acc;
   assign acc = instr_vld_i & (ovf_evt_i | undef_evt_i);

   // R1: reset state (immediate check while in reset)
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         p_reset_r1: assert (epc_o == '0 && cause_o == '0 && !kernel_o);
      end
   end

   p_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |-> !rd_we_o);

   p_pass_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc |-> (rd_we_o == rd_we_req_i));

   p_epc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |=> (epc_o == $past(instr_pc_i)));

   p_cause_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (instr_vld_i && ovf_evt_i && !undef_evt_i) |=> (cause_o == OVF_WORD));

   p_cause_undef_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (instr_vld_i && undef_evt_i && !ovf_evt_i) |=> (cause_o == UNDEF_WORD));

   p_cause_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (instr_vld_i && undef_evt_i && ovf_evt_i) |=> (cause_o == BOTH_WORD));

   p_vector_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |-> (fetch_redir_o && fetch_target_o == HANDLER_VEC));

   p_kernel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |=> kernel_o);

   p_eret_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eret_i && !acc) |-> (fetch_redir_o && fetch_target_o == epc_o));

   p_eret_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eret_i && !acc) |=> !kernel_o);

   p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc |=> ($stable(epc_o) && $stable(cause_o)));

   p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!acc && !eret_i) |-> !fetch_redir_o);

   p_collide_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && eret_i) |=> kernel_o);

endmodule

bind trap_capture_unit trap_capture_chk #(
   .ADDR_W      (ADDR_W),
   .CAUSE_W     (CAUSE_W),
   .CODE_LSB    (CODE_LSB),
   .CODE_W      (CODE_W),
   .OVF_CODE    (OVF_CODE),
   .UNDEF_CODE  (UNDEF_CODE),
   .HANDLER_VEC (HANDLER_VEC),
   .UNDEF_WINS  (UNDEF_WINS)
) chk_i (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .instr_vld_i    (instr_vld_i),
   .instr_pc_i     (instr_pc_i),
   .rd_we_req_i    (rd_we_req_i),
   .ovf_evt_i      (ovf_evt_i),
   .undef_evt_i    (undef_evt_i),
   .eret_i         (eret_i),
   .rd_we_o        (rd_we_o),
   .fetch_redir_o  (fetch_redir_o),
   .fetch_target_o (fetch_target_o),
   .epc_o          (epc_o),
   .cause_o        (cause_o),
   .kernel_o       (kernel_o)
);

// File: tb/trap_capture_unit_tb_top.sv
`timescale 1ns/1ps
module trap_capture_unit_tb_top;

   localparam logic [31:0] VEC = 32'h8000_0180;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [31:0] pc = '0;
   logic        we_req = 1'b0;
   logic        ovf = 1'b0;
   logic        undef = 1'b0;
   logic        eret = 1'b0;
   logic        we;
   logic        redir;
   logic [31:0] target;
   logic [31:0] epc;
   logic [31:0] cause;
   logic        kmode;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   trap_capture_unit dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .instr_vld_i    (vld),
      .instr_pc_i     (pc),
      .rd_we_req_i    (we_req),
      .ovf_evt_i      (ovf),
      .undef_evt_i    (undef),
      .eret_i         (eret),
      .rd_we_o        (we),
      .fetch_redir_o  (redir),
      .fetch_target_o (target),
      .epc_o          (epc),
      .cause_o        (cause),
      .kernel_o       (kmode)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] m_epc;
      logic [31:0] m_cause;
      logic        m_kern;
      m_epc = '0; m_cause = '0; m_kern = 1'b0;

      // R1: reset state, during and after reset
      repeat (2) @(posedge clk);
      #1;
      check("R1", "epc in reset", epc, 32'h0);
      check("R1", "cause in reset", cause, 32'h0);
      check("R1", "kernel in reset", {31'b0, kmode}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", "epc after reset", epc, 32'h0);
      check("R1", "kernel after reset", {31'b0, kmode}, 32'h0);

      for (int round = 0; round < 4; round++) begin
         for (int k = 0; k < 32; k++) begin
            logic        acc;
            logic [31:0] addr;
            string       tg;
            if (round == 3) addr = 32'hFFFF_FFFC - 32'(k * 4);
            else            addr = 32'h0040_0000 + 32'((round * 32 + k) * 4);

            @(negedge clk);
            vld    = k[0];
            we_req = k[1];
            ovf    = k[2];
            undef  = k[3];
            eret   = k[4];
            pc     = addr;
            acc    = vld & (ovf | undef);
            #1;
            // R2 write gate, same cycle
            check(acc ? "R2" : "R10", "rd_we", {31'b0, we}, {31'b0, we_req & ~acc});
            // R7 / R9 / R10 / R11 fetch override, same cycle
            tg = (acc && eret) ? "R11" : acc ? "R7" : eret ? "R9" : "R10";
            check(tg, "redirect", {31'b0, redir}, {31'b0, acc | eret});
            if (acc | eret)
               check(tg, "target", target, acc ? VEC : m_epc);

            @(posedge clk);
            #1;
            if (acc) begin
               m_epc   = addr;
               m_cause = (undef ? 32'd10 : 32'd12) << 2;
               m_kern  = 1'b1;
            end else if (eret) begin
               m_kern  = 1'b0;
            end
            check(acc ? "R3" : "R10", "epc", epc, m_epc);
            tg = !acc ? "R10" : (undef && ovf) ? "R6" : undef ? "R5" : "R4";
            check(tg, "cause", cause, m_cause);
            tg = (acc && eret) ? "R11" : acc ? "R8" : eret ? "R9" : "R10";
            check(tg, "kernel", {31'b0, kmode}, {31'b0, m_kern});
         end
      end

      @(negedge clk);
      vld = 1'b0; ovf = 1'b0; undef = 1'b0; eret = 1'b0; we_req = 1'b0;
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule